// File: doc/BRIEF.md
# SCSI Selection and Transfer Sequencer

This block is the command engine behind a SCSI initiator's register file. When the register block passes it a command strobe, it selects a target (with or without stopping before the command phase), runs a transfer-information phase over an external DMA port, returns the status and message bytes after a command finishes, or acknowledges a message. When each command finishes it writes a fixed status, interrupt and sequence-step triple back to the register block and raises a one-cycle interrupt request.

Device command execution is outside the block. A successful selection raises a device request that carries the target ID. The device answers with a signed data length: positive means data flows in from the device, negative means data flows out to it. The block keeps this signed remaining size. It clamps each DMA transfer to the programmed 16-bit count (zero meaning 65536) and to that remaining size. While command bytes are still being collected, it clamps instead to a 32-byte command cap.

Top module: `scsi_seq_top`

## Requirements
- R1: A selection (opcode 0x42 or 0x43, in `cmdCode[6:0]`) whose target, `busIdLow`, has its `targetPresent` bit clear completes with status 0x80, interrupt 0x20 and sequence step 0.
- R2: A selection with opcode 0x42 to a present target raises `devReq` with `devTarget` equal to the ID and holds it until `devAck`. At that acknowledge it completes with interrupt 0x18, sequence step 4 and status 0x91 when `devLen` is positive, or 0x90 otherwise.
- R3: Opcode 0x43 to a present target raises no device request. It marks a command as pending and completes with status 0x92, interrupt 0x18 and sequence step 4.
- R4: The transfer count is the 16-bit `xferCount`, and a count of zero counts as 65536.
- R5: While a command is pending, a DMA transfer-information command (`cmdCode` 0x90) requests min(count, 32) bytes. When `dmaDone` arrives, the command executes as in R2. The non-DMA form (0x10) executes the command at once.
- R6: With no command pending, transfer information requests min(count, |remaining size|) bytes. `dmaToDev` is 1 exactly when the remaining size is negative, and status bit 4 (terminal count) is cleared when the transfer starts.
- R7: `dmaDone` on a data transfer ORs 0x90 into status, sets interrupt 0x10, and clears the sequence step and the FIFO flags. It pulses `countClr` and moves the remaining size toward zero by the transferred length.
- R8: Initiator-command-complete in DMA mode (0x91) requests 2 bytes toward memory, with `dmaData` holding the sense byte in bits 7:0 and zero in bits 15:8. On `dmaDone` it completes with status 0x93, interrupt 0x18 and sequence step 4.
- R9: Initiator-command-complete in PIO mode (0x11) makes no DMA request. It sets the FIFO flags to 2 and sets the remaining size to 2.
- R10: Message-accepted (0x12 or 0x92) completes with interrupt 0x20 and sequence step 0, leaving status unchanged.
- R11: A selection issued while a transfer is active drops `dmaReq` on the next cycle, clears the remaining size and the pending command, and is then handled as a fresh selection.
- R12: Every completion raises `irq` for exactly one cycle.
- R13: Any non-selection command issued while the block is busy is ignored: outputs and requests stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, one cycle |
| cmdCode | input | 8 | Bit 7 selects DMA mode, bits 6:0 hold the opcode |
| busIdLow | input | 3 | Target ID (low bits of the bus-ID register) |
| targetPresent | input | NUM_TARGETS | One bit per attached target |
| xferCount | input | 16 | Programmed transfer count (mid byte, low byte) |
| senseIn | input | 8 | Sense byte returned by initiator-command-complete |
| devReq | output | 1 | Command execution request to the device |
| devTarget | output | 3 | Target latched at selection |
| devAck | input | 1 | Device answer strobe |
| devLen | input | LEN_W | Signed data length from the device |
| dmaReq | output | 1 | DMA request, held until dmaDone |
| dmaToDev | output | 1 | 1 means memory to device |
| dmaLen | output | LEN_W | Bytes to move |
| dmaData | output | 16 | Response bytes for the DMA write |
| dmaDone | input | 1 | DMA completion strobe |
| statusOut | output | 8 | Status register value |
| intrOut | output | 8 | Interrupt register value |
| seqOut | output | 8 | Sequence-step register value |
| fifoFlags | output | 8 | FIFO flags register value |
| countClr | output | 1 | One-cycle pulse that clears the count registers |
| irq | output | 1 | One-cycle interrupt request |

## Verification
On every cycle, the assertions check that a DMA transfer cannot end without its done strobe and that a device request stays up until it is answered. They also check that a new selection cuts off any active transfer, that the terminal-count bit is clear after a transfer starts, and that the data-completion triple and the count-clear pulse come together. Only the bench scenarios can show the arithmetic: the clamped lengths across sweeps of counts and signed device lengths, zero counting as 65536, and the remaining size carried from one transfer into the next. The same holds for the remaining size being cleared after an abort and for the full sequence of a pending command.

// File: rtl/scsi_seq_pkg.sv
package scsi_seq_pkg;
  localparam logic [6:0] OP_XFER   = 7'h10;
  localparam logic [6:0] OP_CMPL   = 7'h11;
  localparam logic [6:0] OP_MSGOK  = 7'h12;
  localparam logic [6:0] OP_SEL    = 7'h42;
  localparam logic [6:0] OP_SELSTP = 7'h43;

  localparam logic [7:0] ST_INT   = 8'h80;
  localparam logic [7:0] ST_TC    = 8'h10;
  localparam logic [7:0] IN_DISC  = 8'h20;
  localparam logic [7:0] IN_BSFC  = 8'h18;
  localparam logic [7:0] IN_BS    = 8'h10;
  localparam logic [7:0] SEQ_CMD  = 8'h04;

  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_DMA_DATA, S_DMA_CMD, S_DMA_RESP
  } seqState_t;

  typedef struct packed {
    logic abort;
    logic ldTarget;
    logic noTarget;
    logic selDone;
    logic stopDone;
    logic dmaStart;
    logic xferDone;
    logic cmdTaken;
    logic respStart;
    logic respDone;
    logic respPio;
    logic msgAcc;
  } seqStrobe_t;
endpackage

// File: rtl/scsi_seq_ctrl.sv
module scsi_seq_ctrl
  import scsi_seq_pkg::*;
#(
  parameter int NUM_TARGETS = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdValid,
  input  logic [7:0]             cmdCode,
  input  logic [2:0]             busIdLow,
  input  logic [NUM_TARGETS-1:0] targetPresent,
  input  logic                   cmdPending,
  input  logic                   devAck,
  input  logic                   dmaDone,
  output logic                   devReq,
  output logic                   dmaReq,
  output seqStrobe_t             str
);
  seqState_t state, nextState;
  logic [6:0] opcode;
  logic       dmaMode, selCmd, targetOk;

  assign opcode   = cmdCode[6:0];
  assign dmaMode  = cmdCode[7];
  assign selCmd   = cmdValid && (opcode == OP_SEL || opcode == OP_SELSTP);
  assign targetOk = (32'(busIdLow) < NUM_TARGETS) && targetPresent[busIdLow];
  assign devReq   = (state == S_DEV);
  assign dmaReq   = (state == S_DMA_DATA) || (state == S_DMA_CMD) || (state == S_DMA_RESP);

  always_comb begin
    str       = '0;
    nextState = state;
    if (selCmd) begin
      str.abort = (state != S_IDLE);
      nextState = S_IDLE;
      if (!targetOk) begin
        str.noTarget = 1'b1;
      end else begin
        str.ldTarget = 1'b1;
        if (opcode == OP_SEL) nextState = S_DEV;
        else                  str.stopDone = 1'b1;
      end
    end else begin
      unique case (state)
        S_IDLE: if (cmdValid) begin
          unique case (opcode)
            OP_XFER: begin
              if (dmaMode) begin
                str.dmaStart = 1'b1;
                nextState    = cmdPending ? S_DMA_CMD : S_DMA_DATA;
              end else if (cmdPending) begin
                str.cmdTaken = 1'b1;
                nextState    = S_DEV;
              end
            end
            OP_CMPL: begin
              if (dmaMode) begin
                str.respStart = 1'b1;
                nextState     = S_DMA_RESP;
              end else begin
                str.respPio = 1'b1;
              end
            end
            OP_MSGOK: str.msgAcc = 1'b1;
            default: ;
          endcase
        end
        S_DEV: if (devAck) begin
          str.selDone = 1'b1;
          nextState   = S_IDLE;
        end
        S_DMA_DATA: if (dmaDone) begin
          str.xferDone = 1'b1;
          nextState    = S_IDLE;
        end
        S_DMA_CMD: if (dmaDone) begin
          str.cmdTaken = 1'b1;
          nextState    = S_DEV;
        end
        S_DMA_RESP: if (dmaDone) begin
          str.respDone = 1'b1;
          nextState    = S_IDLE;
        end
        default: nextState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  // R11: a selection during a transfer ends the DMA request
  p_abort_drops_dma_r11: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && selCmd) |=> !dmaReq);
  // R2: the device request waits for its answer
  p_dev_req_held_r2: assert property (@(posedge clk) disable iff (!rstN)
    (devReq && !devAck && !selCmd) |=> devReq);
  // R13: a busy transfer only ends on done or selection
  p_busy_holds_r13: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && !dmaDone && !selCmd) |=> dmaReq);
endmodule

// File: rtl/scsi_seq_datapath.sv
module scsi_seq_datapath
  import scsi_seq_pkg::*;
#(
  parameter int LEN_W   = 18,
  parameter int CMD_CAP = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  seqStrobe_t              str,
  input  logic [2:0]              busIdLow,
  input  logic [15:0]             xferCount,
  input  logic [7:0]              senseIn,
  input  logic signed [LEN_W-1:0] devLen,
  output logic                    cmdPending,
  output logic [2:0]              devTarget,
  output logic [LEN_W-1:0]        dmaLen,
  output logic                    dmaToDev,
  output logic [15:0]             dmaData,
  output logic [7:0]              statusOut,
  output logic [7:0]              intrOut,
  output logic [7:0]              seqOut,
  output logic [7:0]              fifoFlags,
  output logic                    countClr,
  output logic                    irq
);
  localparam logic [LEN_W-1:0] FULL_COUNT = LEN_W'(32'h10000);
  localparam logic [LEN_W-1:0] CAP_LEN    = LEN_W'(CMD_CAP);

  logic signed [LEN_W-1:0] remSize;
  logic [LEN_W-1:0] countEff, remMag, limit, lenCalc, xferLen;
  logic [7:0] senseReg;
  logic       toDevReg;

  assign countEff = (xferCount == 16'h0) ? FULL_COUNT : LEN_W'(xferCount);
  assign remMag   = remSize[LEN_W-1] ? LEN_W'(-remSize) : LEN_W'(remSize);
  assign limit    = cmdPending ? CAP_LEN : remMag;
  assign lenCalc  = (countEff < limit) ? countEff : limit;

  assign dmaLen   = xferLen;
  assign dmaToDev = toDevReg;
  assign dmaData  = {8'h00, senseReg};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remSize    <= '0;
      xferLen    <= '0;
      toDevReg   <= 1'b0;
      senseReg   <= '0;
      cmdPending <= 1'b0;
      devTarget  <= '0;
      statusOut  <= '0;
      intrOut    <= '0;
      seqOut     <= '0;
      fifoFlags  <= '0;
      countClr   <= 1'b0;
      irq        <= 1'b0;
    end else begin
      countClr <= str.xferDone;
      irq      <= str.noTarget | str.selDone | str.stopDone | str.xferDone |
                  str.respDone | str.respPio | str.msgAcc;
      if (str.abort) begin
        remSize    <= '0;
        cmdPending <= 1'b0;
      end
      if (str.ldTarget) devTarget <= busIdLow;
      if (str.noTarget) begin
        statusOut <= ST_INT;
        intrOut   <= IN_DISC;
        seqOut    <= '0;
        remSize   <= '0;
      end
      if (str.selDone) begin
        statusOut <= ST_INT | ST_TC | {7'h0, (devLen > 0)};
        intrOut   <= IN_BSFC;
        seqOut    <= SEQ_CMD;
        remSize   <= devLen;
      end
      if (str.stopDone) begin
        statusOut  <= ST_INT | ST_TC | 8'h02;
        intrOut    <= IN_BSFC;
        seqOut     <= SEQ_CMD;
        remSize    <= '0;
        cmdPending <= 1'b1;
      end
      if (str.dmaStart) begin
        statusOut <= statusOut & ~ST_TC;
        xferLen   <= lenCalc;
        toDevReg  <= remSize[LEN_W-1];
      end
      if (str.xferDone) begin
        statusOut <= statusOut | ST_INT | ST_TC;
        intrOut   <= IN_BS;
        seqOut    <= '0;
        fifoFlags <= '0;
        remSize   <= remSize[LEN_W-1] ? remSize + $signed(xferLen)
                                      : remSize - $signed(xferLen);
      end
      if (str.cmdTaken) begin
        cmdPending <= 1'b0;
        remSize    <= '0;
      end
      if (str.respStart) begin
        senseReg <= senseIn;
        xferLen  <= LEN_W'(2);
        toDevReg <= 1'b0;
      end
      if (str.respDone) begin
        statusOut <= ST_INT | ST_TC | 8'h03;
        intrOut   <= IN_BSFC;
        seqOut    <= SEQ_CMD;
      end
      if (str.respPio) begin
        senseReg  <= senseIn;
        remSize   <= LEN_W'(2);
        fifoFlags <= 8'h02;
      end
      if (str.msgAcc) begin
        intrOut <= IN_DISC;
        seqOut  <= '0;
      end
    end
  end

  // R6: the terminal-count bit is low once a transfer has started
  p_tc_cleared_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(str.dmaStart) |-> !statusOut[4]);
  // R5: a pending command never moves more than the cap
  p_cmd_cap_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(str.dmaStart) && cmdPending) |-> (dmaLen <= CAP_LEN));
  // R7: the count clear comes with the data-completion triple
  p_done_triple_r7: assert property (@(posedge clk) disable iff (!rstN)
    countClr |-> (statusOut[7] && statusOut[4] && intrOut == IN_BS &&
                  seqOut == 8'h0 && fifoFlags == 8'h0 && irq));
  // R12: the count clear is a single-cycle pulse
  p_clr_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    countClr |=> !countClr);
endmodule

// File: rtl/scsi_seq_top.sv
module scsi_seq_top
  import scsi_seq_pkg::*;
#(
  parameter int NUM_TARGETS = 8,
  parameter int LEN_W       = 18,
  parameter int CMD_CAP     = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cmdValid,
  input  logic [7:0]              cmdCode,
  input  logic [2:0]              busIdLow,
  input  logic [NUM_TARGETS-1:0]  targetPresent,
  input  logic [15:0]             xferCount,
  input  logic [7:0]              senseIn,
  output logic                    devReq,
  output logic [2:0]              devTarget,
  input  logic                    devAck,
  input  logic signed [LEN_W-1:0] devLen,
  output logic                    dmaReq,
  output logic                    dmaToDev,
  output logic [LEN_W-1:0]        dmaLen,
  output logic [15:0]             dmaData,
  input  logic                    dmaDone,
  output logic [7:0]              statusOut,
  output logic [7:0]              intrOut,
  output logic [7:0]              seqOut,
  output logic [7:0]              fifoFlags,
  output logic                    countClr,
  output logic                    irq
);
  seqStrobe_t str;
  logic       cmdPending;

  scsi_seq_ctrl #(.NUM_TARGETS(NUM_TARGETS)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .busIdLow(busIdLow), .targetPresent(targetPresent),
    .cmdPending(cmdPending), .devAck(devAck), .dmaDone(dmaDone),
    .devReq(devReq), .dmaReq(dmaReq), .str(str)
  );

  scsi_seq_datapath #(.LEN_W(LEN_W), .CMD_CAP(CMD_CAP)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .busIdLow(busIdLow),
    .xferCount(xferCount), .senseIn(senseIn), .devLen(devLen),
    .cmdPending(cmdPending), .devTarget(devTarget), .dmaLen(dmaLen),
    .dmaToDev(dmaToDev), .dmaData(dmaData), .statusOut(statusOut),
    .intrOut(intrOut), .seqOut(seqOut), .fifoFlags(fifoFlags),
    .countClr(countClr), .irq(irq)
  );
endmodule

// File: tb/tb_scsi_seq_top.sv
`timescale 1ns/1ps
module tb_scsi_seq_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [7:0] cmdCode = '0;
  logic [2:0] busIdLow = '0;
  logic [7:0] targetPresent = 8'b1010_0110;
  logic [15:0] xferCount = '0;
  logic [7:0] senseIn = '0;
  logic devReq, dmaReq, dmaToDev, countClr, irq;
  logic [2:0] devTarget;
  logic devAck = 1'b0, dmaDone = 1'b0;
  logic signed [17:0] devLen = '0;
  logic [17:0] dmaLen;
  logic [15:0] dmaData;
  logic [7:0] statusOut, intrOut, seqOut, fifoFlags;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  scsi_seq_top dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .busIdLow(busIdLow), .targetPresent(targetPresent), .xferCount(xferCount),
    .senseIn(senseIn), .devReq(devReq), .devTarget(devTarget), .devAck(devAck),
    .devLen(devLen), .dmaReq(dmaReq), .dmaToDev(dmaToDev), .dmaLen(dmaLen),
    .dmaData(dmaData), .dmaDone(dmaDone), .statusOut(statusOut),
    .intrOut(intrOut), .seqOut(seqOut), .fifoFlags(fifoFlags),
    .countClr(countClr), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input longint act, input longint exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic issue(input logic [7:0] code);
    cmdCode = code; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic answer(input int len);
    devLen = 18'(len); devAck = 1'b1;
    @(negedge clk);
    devAck = 1'b0;
  endtask

  task automatic finishDma;
    dmaDone = 1'b1;
    @(negedge clk);
    dmaDone = 1'b0;
  endtask

  task automatic irqOnce(input string req);
    eq(req, irq, 1);
    @(negedge clk);
    eq(req, irq, 0);
  endtask

  function automatic longint expLen(input int cnt, input longint rem, input bit pend);
    longint eff, lim;
    eff = (cnt == 0) ? 65536 : cnt;
    lim = pend ? 32 : ((rem < 0) ? -rem : rem);
    return (eff < lim) ? eff : lim;
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int lens[6] = '{100, -100, 1, -40000, 70000, 0};
    int cnts[5] = '{0, 1, 32, 100, 65535};
    int capCnts[4] = '{0, 5, 32, 40};
    longint rem, l1, l2;
    logic [7:0] st;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    eq("reset status", statusOut, 0); eq("reset intr", intrOut, 0);
    eq("reset dmaReq", dmaReq, 0); eq("reset devReq", devReq, 0);
    eq("reset irq", irq, 0);

    // R1: absent targets, sweep every ID
    for (int id = 0; id < 8; id++) begin
      busIdLow = 3'(id);
      issue(8'h42);
      if (!targetPresent[id]) begin
        eq("R1 status", statusOut, 8'h80); eq("R1 intr", intrOut, 8'h20);
        eq("R1 seq", seqOut, 0); eq("R1 devReq", devReq, 0);
        irqOnce("R1 irq");
      end else begin
        eq("R2 devReq", devReq, 1); eq("R2 devTarget", devTarget, id);
        @(negedge clk);
        eq("R2 held", devReq, 1);
        answer(0);
        eq("R2 status zero len", statusOut, 8'h90);
        irqOnce("R12 irq");
      end
    end

    // R4 R6 R7: sweep device lengths against counts
    busIdLow = 3'd1;
    foreach (lens[i]) foreach (cnts[j]) begin
      issue(8'hC2);
      eq("R2 devReq", devReq, 1);
      answer(lens[i]);
      st = 8'h90 | ((lens[i] > 0) ? 8'h01 : 8'h00);
      eq("R2 status", statusOut, st); eq("R2 intr", intrOut, 8'h18);
      eq("R2 seq", seqOut, 4);
      irqOnce("R12 sel irq");
      rem = lens[i];
      xferCount = 16'(cnts[j]);
      issue(8'h90);
      l1 = expLen(cnts[j], rem, 0);
      eq("R4 R6 len", dmaLen, l1); eq("R6 dir", dmaToDev, (rem < 0));
      eq("R6 req", dmaReq, 1); eq("R6 tc clear", statusOut, st & 8'hEF);
      finishDma();
      eq("R7 status", statusOut, st); eq("R7 intr", intrOut, 8'h10);
      eq("R7 seq", seqOut, 0); eq("R7 flags", fifoFlags, 0);
      eq("R7 countClr", countClr, 1); eq("R7 dmaReq", dmaReq, 0);
      irqOnce("R12 done irq");
      eq("R12 countClr pulse", countClr, 0);
      rem = (rem < 0) ? rem + l1 : rem - l1;
      xferCount = 16'h0;
      issue(8'h90);
      l2 = expLen(0, rem, 0);
      eq("R7 remaining carried", dmaLen, l2);
      finishDma();
      @(negedge clk);
    end

    // R3 R5: pending command with DMA collection
    foreach (capCnts[k]) begin
      issue(8'h43);
      eq("R3 status", statusOut, 8'h92); eq("R3 intr", intrOut, 8'h18);
      eq("R3 seq", seqOut, 4); eq("R3 no devReq", devReq, 0);
      irqOnce("R3 irq");
      xferCount = 16'(capCnts[k]);
      issue(8'h90);
      eq("R5 cap len", dmaLen, expLen(capCnts[k], 0, 1));
      eq("R5 no irq at start", irq, 0);
      finishDma();
      eq("R5 exec devReq", devReq, 1); eq("R5 no irq yet", irq, 0);
      answer(50);
      eq("R5 status", statusOut, 8'h91);
      irqOnce("R5 irq");
    end
    // R5: PIO form executes at once
    issue(8'h43);
    @(negedge clk);
    issue(8'h10);
    eq("R5 pio exec devReq", devReq, 1); eq("R5 pio dmaReq", dmaReq, 0);
    answer(-8);
    eq("R5 pio status", statusOut, 8'h90);
    @(negedge clk);

    // R8: status bytes over DMA
    senseIn = 8'h5A;
    issue(8'h91);
    eq("R8 req", dmaReq, 1); eq("R8 len", dmaLen, 2); eq("R8 dir", dmaToDev, 0);
    eq("R8 data", dmaData, 16'h005A);
    senseIn = 8'h00;
    finishDma();
    eq("R8 status", statusOut, 8'h93); eq("R8 intr", intrOut, 8'h18);
    eq("R8 seq", seqOut, 4);
    irqOnce("R8 irq");

    // R9: status bytes by PIO, then remaining size 2 seen by a transfer
    issue(8'h11);
    eq("R9 flags", fifoFlags, 2); eq("R9 no dma", dmaReq, 0);
    irqOnce("R9 irq");
    xferCount = 16'd100;
    issue(8'h90);
    eq("R9 remaining 2", dmaLen, 2); eq("R9 dir", dmaToDev, 0);

    // R13: message-accepted while busy is ignored
    st = statusOut;
    issue(8'h12);
    eq("R13 still busy", dmaReq, 1); eq("R13 no irq", irq, 0);
    eq("R13 intr kept", intrOut, 8'h18); eq("R13 status kept", statusOut, st);
    finishDma();
    @(negedge clk);

    // R10: message-accepted
    st = statusOut;
    issue(8'h12);
    eq("R10 intr", intrOut, 8'h20); eq("R10 seq", seqOut, 0);
    eq("R10 status kept", statusOut, st);
    irqOnce("R10 irq");

    // R11: abort a transfer with a fresh selection
    busIdLow = 3'd1;
    issue(8'h42);
    answer(100);
    xferCount = 16'd10;
    issue(8'h90);
    eq("R11 running", dmaReq, 1);
    busIdLow = 3'd0;
    issue(8'h42);
    eq("R11 dropped", dmaReq, 0); eq("R11 status", statusOut, 8'h80);
    irqOnce("R11 irq");
    xferCount = 16'd5;
    issue(8'h90);
    eq("R11 remaining cleared", dmaLen, 0);
    finishDma();
    @(negedge clk);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule